// File: doc/BRIEF.md
# Low-Power Mode and Wake Controller

This block holds the operating mode of a small signal-processing controller and turns it into clock-enable outputs for the core, the memories and the peripherals. It has five modes: Run, Wait, Stop, Standby and Power-Down. The core moves the system into Wait or Stop with a one-cycle instruction strobe. Standby and Power-Down are reached through configuration bits, which clock-generation logic elsewhere on the chip supplies and holds.

Each mode accepts its own set of wake events. In Wait, any interrupt, a debug-entry request or a reset brings the system back to Run. In Stop, only these do so:
- the interrupt of a peripheral that has been told to keep its clock through Stop;
- the low-voltage interrupt;
- a debug-entry request;
- a reset.

Standby is left only after its configuration has been undone and the PLL reports lock. Power-Down ignores every event except an external reset or a power-on reset. The analog oscillator, PLL and regulator are outside this block. The block only observes their configuration and lock state.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After a power-on reset (`rst_n` low at a clock edge) the mode is Run (code 0). In Run, master, core, memory, peripheral, high-speed-peripheral, every timer and the serial clock enable are all 1, and `slow_clk_sel` is 0.
- R2: In Run, a `wait_strobe` with no `stop_strobe` moves the mode to Wait (code 1) at the next edge. In Wait, core and memory enables are 0, and all peripheral, timer, serial, high-speed and master enables stay 1.
- R3: In Wait, any bit of `irq_req`, `tmr_irq`, `sci_irq`, `lvi_irq` or `dbg_req` returns the mode to Run at the next edge.
- R4: In Run, a `stop_strobe` moves the mode to Stop (code 2) at the next edge, even if `wait_strobe` is also high. In Stop, core, memory, peripheral and high-speed enables are 0 and the master enable stays 1.
- R5: In Stop, `tmr_clk_en[i]` equals `tmr_stop_keep[i]` and `sci_clk_en` equals `sci_stop_keep`.
- R6: In Stop, only these return the mode to Run at the next edge: `tmr_irq[i]` with `tmr_stop_keep[i]` set, `sci_irq` with `sci_stop_keep` set, `lvi_irq`, or `dbg_req`. `irq_req` and interrupts from peripherals whose keep bit is clear leave the mode in Stop.
- R7: In Run with no strobe, the mode moves to Standby (code 3) at the next edge when all four of these are 1: `cfg_relax_sel`, `cfg_pll_off`, `cfg_osc_stby`, `cfg_reg_stby`. In Standby, core, memory, peripheral, timer, serial and master enables are 1, the high-speed enable is 0 and `slow_clk_sel` is 1.
- R8: Standby returns to Run only when all four standby configuration bits are 0 and `pll_locked` is 1. Otherwise it stays in Standby.
- R9: In Standby, `cfg_osc_off` = 1 moves the mode to Power-Down (code 4). In Power-Down every clock enable, including the master enable, is 0.
- R10: Power-Down is left only through `ext_rst` (to Run at the next edge) or a power-on reset. `sw_rst`, `wdog_rst`, interrupts and debug requests have no effect on it.
- R11: In Run, Wait, Stop or Standby, a pulse on `ext_rst`, `sw_rst` or `wdog_rst` forces the mode to Run at the next edge.
- R12: `wait_strobe` and `stop_strobe` have no effect outside Run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| ext_rst | input | 1 | External reset request |
| sw_rst | input | 1 | Software reset request |
| wdog_rst | input | 1 | Watchdog reset request |
| wait_strobe | input | 1 | Core executed a wait instruction |
| stop_strobe | input | 1 | Core executed a stop instruction |
| irq_req | input | N_IRQ | General interrupt requests |
| tmr_irq | input | N_TMR | Timer channel interrupts |
| tmr_stop_keep | input | N_TMR | Keep timer channel clocked in Stop |
| sci_irq | input | 1 | Serial interface interrupt |
| sci_stop_keep | input | 1 | Keep serial interface clocked in Stop |
| lvi_irq | input | 1 | Low-voltage interrupt |
| dbg_req | input | 1 | Debug-entry request |
| cfg_relax_sel | input | 1 | Relaxation oscillator selected as clock source |
| cfg_pll_off | input | 1 | PLL powered down |
| cfg_osc_stby | input | 1 | Oscillator in standby |
| cfg_reg_stby | input | 1 | Large regulator in standby |
| cfg_osc_off | input | 1 | Oscillator powered down |
| pll_locked | input | 1 | PLL lock indication |
| master_clk_en | output | 1 | Master clock generation enable |
| core_clk_en | output | 1 | Core clock enable |
| mem_clk_en | output | 1 | Memory clock enable |
| per_clk_en | output | 1 | General peripheral clock enable |
| hs_per_clk_en | output | 1 | High-speed peripheral clock enable |
| tmr_clk_en | output | N_TMR | Per-channel timer clock enables |
| sci_clk_en | output | 1 | Serial interface clock enable |
| slow_clk_sel | output | 1 | 1 selects the 200 kHz low-rate system clock |
| mode_code | output | 3 | 0 Run, 1 Wait, 2 Stop, 3 Standby, 4 Power-Down |

## Verification
The assertions assume that every input is synchronous to `clk` and that `rst_n` is low at the first edge, so the mode register never holds an undefined value. They also assume that reset requests and wake events are sampled at the same edge as the strobes, with no ordering among them. The stimulus therefore changes inputs one time unit after a rising edge and samples the outputs after the next edge. Each event is held for exactly one cycle, so a wake event, a strobe and a reset never overlap unless a scenario combines them on purpose.

// File: rtl/pwr_mode_pkg.sv
// Package: shared mode encoding for the power-mode controller.
// Assumes the 3-bit code is visible to software as-is, so values are fixed.
package pwr_mode_pkg;

    typedef enum logic [2:0] {
        MODE_RUN  = 3'd0,
        MODE_WAIT = 3'd1,
        MODE_STOP = 3'd2,
        MODE_STBY = 3'd3,
        MODE_PDN  = 3'd4
    } pwr_mode_e;

endpackage

// File: rtl/pwr_wake_filter.sv
// Wake qualification: reduces all interrupt and debug sources into one wake
// flag per low-power mode. In the Stop flag, a peripheral interrupt counts only
// when that peripheral's keep-clock bit is set. Purely combinational; assumes
// the inputs are synchronous to the controller clock.
module pwr_wake_filter #(
    parameter int N_IRQ = 8,
    parameter int N_TMR = 4
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_TMR-1:0] tmr_irq,
    input  logic [N_TMR-1:0] tmr_stop_keep,
    input  logic             sci_irq,
    input  logic             sci_stop_keep,
    input  logic             lvi_irq,
    input  logic             dbg_req,
    output logic             wake_wait,
    output logic             wake_stop
);

    logic [N_TMR-1:0] tmr_stop_hit;

    // One qualifier per timer channel: interrupt counts only if its clock survives Stop.
    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr_qual
        assign tmr_stop_hit[g] = tmr_irq[g] & tmr_stop_keep[g];
    end

    // Wait accepts every interrupt source and debug entry.
    always_comb begin
        wake_wait = (|irq_req) | (|tmr_irq) | sci_irq | lvi_irq | dbg_req;
    end

    // Stop accepts only clocked peripherals, low voltage and debug entry.
    always_comb begin
        wake_stop = (|tmr_stop_hit) | (sci_irq & sci_stop_keep) | lvi_irq | dbg_req;
    end

endmodule

// File: rtl/pwr_mode_fsm.sv
// Mode register and transition rules. Strobes are honoured only in Run.
// Stop beats Wait, and Wait beats Standby entry. Standby exits after its
// configuration is cleared and the PLL reports lock. Power-Down yields only to
// the external reset or the power-on reset (rst_n, synchronous, active low).
module pwr_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ext_rst,
    input  logic      sw_rst,
    input  logic      wdog_rst,
    input  logic      wait_strobe,
    input  logic      stop_strobe,
    input  logic      wake_wait,
    input  logic      wake_stop,
    input  logic      stby_all_set,
    input  logic      stby_all_clear,
    input  logic      cfg_osc_off,
    input  logic      pll_locked,
    output pwr_mode_e mode
);

    pwr_mode_e mode_nxt;
    logic      soft_rst;

    // Resets that can reach the controller only while some clock still runs.
    always_comb begin
        soft_rst = sw_rst | wdog_rst;
    end

    // Next-mode selection with reset overrides applied last.
    always_comb begin
        mode_nxt = mode;
        unique case (mode)
            MODE_RUN: begin
                if (stop_strobe)       mode_nxt = MODE_STOP;
                else if (wait_strobe)  mode_nxt = MODE_WAIT;
                else if (stby_all_set) mode_nxt = MODE_STBY;
            end
            MODE_WAIT: if (wake_wait) mode_nxt = MODE_RUN;
            MODE_STOP: if (wake_stop) mode_nxt = MODE_RUN;
            MODE_STBY: begin
                if (cfg_osc_off)                       mode_nxt = MODE_PDN;
                else if (stby_all_clear && pll_locked) mode_nxt = MODE_RUN;
            end
            MODE_PDN: mode_nxt = MODE_PDN;
            default:  mode_nxt = MODE_RUN;
        endcase
        if (soft_rst && mode != MODE_PDN) mode_nxt = MODE_RUN;
        if (ext_rst)                      mode_nxt = MODE_RUN;
    end

    // Mode register with synchronous power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= MODE_RUN;
        else        mode <= mode_nxt;
    end

    AST_WAIT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && wait_strobe && !stop_strobe && !ext_rst && !soft_rst)
        |=> mode == MODE_WAIT); // R2
    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && stop_strobe) |=> mode inside {MODE_STOP, MODE_RUN}); // R4
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STOP && !wake_stop && !ext_rst && !soft_rst) |=> mode == MODE_STOP); // R6
    AST_STBY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STBY && !pll_locked && !ext_rst && !soft_rst)
        |=> mode inside {MODE_STBY, MODE_PDN}); // R8
    AST_PDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PDN && !ext_rst) |=> mode == MODE_PDN); // R10
    AST_RST_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rst || (soft_rst && mode != MODE_PDN)) |=> mode == MODE_RUN); // R11

endmodule

// File: rtl/pwr_clk_gate.sv
// Clock-enable decode: maps the current mode and the per-peripheral keep bits
// onto every enable output and the low-rate select. Purely combinational;
// assumes the mode input comes straight from the mode register.
module pwr_clk_gate
    import pwr_mode_pkg::*;
#(
    parameter int N_TMR = 4
) (
    input  pwr_mode_e        mode,
    input  logic [N_TMR-1:0] tmr_stop_keep,
    input  logic             sci_stop_keep,
    output logic             master_clk_en,
    output logic             core_clk_en,
    output logic             mem_clk_en,
    output logic             per_clk_en,
    output logic             hs_per_clk_en,
    output logic [N_TMR-1:0] tmr_clk_en,
    output logic             sci_clk_en,
    output logic             slow_clk_sel
);

    logic in_run, in_wait, in_stop, in_stby;

    // One-hot view of the mode for the decode terms below.
    always_comb begin
        in_run  = (mode == MODE_RUN);
        in_wait = (mode == MODE_WAIT);
        in_stop = (mode == MODE_STOP);
        in_stby = (mode == MODE_STBY);
    end

    // Group enables shared by all consumers of a clock domain.
    always_comb begin
        master_clk_en = in_run | in_wait | in_stop | in_stby;
        core_clk_en   = in_run | in_stby;
        mem_clk_en    = in_run | in_stby;
        per_clk_en    = in_run | in_wait | in_stby;
        hs_per_clk_en = in_run | in_wait;
        slow_clk_sel  = ~(in_run | in_wait | in_stop);
        sci_clk_en    = per_clk_en | (in_stop & sci_stop_keep);
    end

    // Per-channel timer enables: running domain, or kept alive through Stop.
    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr_en
        assign tmr_clk_en[g] = per_clk_en | (in_stop & tmr_stop_keep[g]);
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Top of the low-power mode and wake controller: joins the wake filter, the
// mode register and the clock-enable decode. Assumes all inputs are
// synchronous to clk and rst_n is a synchronous active-low power-on reset.
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int N_TMR = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_rst,
    input  logic             sw_rst,
    input  logic             wdog_rst,
    input  logic             wait_strobe,
    input  logic             stop_strobe,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_TMR-1:0] tmr_irq,
    input  logic [N_TMR-1:0] tmr_stop_keep,
    input  logic             sci_irq,
    input  logic             sci_stop_keep,
    input  logic             lvi_irq,
    input  logic             dbg_req,
    input  logic             cfg_relax_sel,
    input  logic             cfg_pll_off,
    input  logic             cfg_osc_stby,
    input  logic             cfg_reg_stby,
    input  logic             cfg_osc_off,
    input  logic             pll_locked,
    output logic             master_clk_en,
    output logic             core_clk_en,
    output logic             mem_clk_en,
    output logic             per_clk_en,
    output logic             hs_per_clk_en,
    output logic [N_TMR-1:0] tmr_clk_en,
    output logic             sci_clk_en,
    output logic             slow_clk_sel,
    output logic [2:0]       mode_code
);

    pwr_mode_e mode;
    logic      wake_wait, wake_stop;
    logic      stby_all_set, stby_all_clear;

    // Standby configuration summary: fully applied or fully undone.
    always_comb begin
        stby_all_set   = cfg_relax_sel & cfg_pll_off & cfg_osc_stby & cfg_reg_stby;
        stby_all_clear = ~(cfg_relax_sel | cfg_pll_off | cfg_osc_stby | cfg_reg_stby);
    end

    pwr_wake_filter #(.N_IRQ(N_IRQ), .N_TMR(N_TMR)) u_wake (
        .irq_req       (irq_req),
        .tmr_irq       (tmr_irq),
        .tmr_stop_keep (tmr_stop_keep),
        .sci_irq       (sci_irq),
        .sci_stop_keep (sci_stop_keep),
        .lvi_irq       (lvi_irq),
        .dbg_req       (dbg_req),
        .wake_wait     (wake_wait),
        .wake_stop     (wake_stop)
    );

    pwr_mode_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .ext_rst        (ext_rst),
        .sw_rst         (sw_rst),
        .wdog_rst       (wdog_rst),
        .wait_strobe    (wait_strobe),
        .stop_strobe    (stop_strobe),
        .wake_wait      (wake_wait),
        .wake_stop      (wake_stop),
        .stby_all_set   (stby_all_set),
        .stby_all_clear (stby_all_clear),
        .cfg_osc_off    (cfg_osc_off),
        .pll_locked     (pll_locked),
        .mode           (mode)
    );

    pwr_clk_gate #(.N_TMR(N_TMR)) u_gate (
        .mode          (mode),
        .tmr_stop_keep (tmr_stop_keep),
        .sci_stop_keep (sci_stop_keep),
        .master_clk_en (master_clk_en),
        .core_clk_en   (core_clk_en),
        .mem_clk_en    (mem_clk_en),
        .per_clk_en    (per_clk_en),
        .hs_per_clk_en (hs_per_clk_en),
        .tmr_clk_en    (tmr_clk_en),
        .sci_clk_en    (sci_clk_en),
        .slow_clk_sel  (slow_clk_sel)
    );

    // Export the mode code unchanged.
    always_comb begin
        mode_code = mode;
    end

    AST_CORE_MEM_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en == mem_clk_en); // R2
    AST_RUN_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 3'd0) |-> (core_clk_en && per_clk_en && hs_per_clk_en && !slow_clk_sel)); // R1
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 3'd2) |-> (!core_clk_en && !per_clk_en && master_clk_en
                                 && ((tmr_clk_en & ~tmr_stop_keep) == '0))); // R5
    AST_PDN_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 3'd4) |-> (!master_clk_en && !core_clk_en && !per_clk_en
                                 && tmr_clk_en == '0 && !sci_clk_en)); // R9
    AST_STBY_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 3'd3) |-> (slow_clk_sel && !hs_per_clk_en && core_clk_en)); // R7

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module pwr_mode_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_IRQ = 8;
    localparam int N_TMR = 4;

    logic clk = 1'b0;
    logic rst_n, ext_rst, sw_rst, wdog_rst, wait_strobe, stop_strobe;
    logic [N_IRQ-1:0] irq_req;
    logic [N_TMR-1:0] tmr_irq, tmr_stop_keep, tmr_clk_en;
    logic sci_irq, sci_stop_keep, lvi_irq, dbg_req;
    logic cfg_relax_sel, cfg_pll_off, cfg_osc_stby, cfg_reg_stby, cfg_osc_off, pll_locked;
    logic master_clk_en, core_clk_en, mem_clk_en, per_clk_en, hs_per_clk_en;
    logic sci_clk_en, slow_clk_sel;
    logic [2:0] mode_code;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_ctrl #(.N_IRQ(N_IRQ), .N_TMR(N_TMR)) u_dut (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Enables packed as {master,core,mem,per,hs,sci,slow}.
    task automatic chk_out(string tag, logic [6:0] en, logic [N_TMR-1:0] tmr, logic [2:0] code);
        chk({tag, " mode"}, mode_code, code);
        chk({tag, " enables"}, {master_clk_en, core_clk_en, mem_clk_en, per_clk_en,
                                hs_per_clk_en, sci_clk_en, slow_clk_sel}, en);
        chk({tag, " timers"}, tmr_clk_en, tmr);
    endtask

    task automatic idle_inputs();
        ext_rst = 0; sw_rst = 0; wdog_rst = 0; wait_strobe = 0; stop_strobe = 0;
        irq_req = '0; tmr_irq = '0; tmr_stop_keep = '0; sci_irq = 0; sci_stop_keep = 0;
        lvi_irq = 0; dbg_req = 0; cfg_relax_sel = 0; cfg_pll_off = 0; cfg_osc_stby = 0;
        cfg_reg_stby = 0; cfg_osc_off = 0; pll_locked = 1;
    endtask

    task automatic enter_stop();
        stop_strobe = 1; tick(); stop_strobe = 0;
    endtask

    task automatic t_reset();
        idle_inputs();
        rst_n = 0; tick(); tick();
        rst_n = 1;
        chk_out("R1 reset run", 7'b1111110, 4'b1111, 3'd0);
        tick();
        chk_out("R1 run steady", 7'b1111110, 4'b1111, 3'd0);
    endtask

    task automatic t_wait();
        wait_strobe = 1; tick(); wait_strobe = 0;
        chk_out("R2 wait", 7'b1001110, 4'b1111, 3'd1);
        tick();
        chk("R2 wait holds", mode_code, 3'd1);
        irq_req = 8'h10; tick(); irq_req = '0;
        chk("R3 wake by irq", mode_code, 3'd0);
        wait_strobe = 1; tick(); wait_strobe = 0;
        tmr_irq = 4'b1000; tick(); tmr_irq = '0;
        chk("R3 wake by unkept timer", mode_code, 3'd0);
        wait_strobe = 1; tick(); wait_strobe = 0;
        dbg_req = 1; tick(); dbg_req = 0;
        chk("R3 wake by debug", mode_code, 3'd0);
    endtask

    task automatic t_stop();
        tmr_stop_keep = 4'b0101; sci_stop_keep = 0;
        stop_strobe = 1; wait_strobe = 1; tick(); stop_strobe = 0; wait_strobe = 0;
        chk_out("R4 stop wins", 7'b1000000, 4'b0101, 3'd2);
        sci_stop_keep = 1; #1;
        chk_out("R5 sci kept", 7'b1000010, 4'b0101, 3'd2);
        sci_stop_keep = 0;
        irq_req = 8'hFF; tick(); irq_req = '0;
        chk("R6 general irq ignored", mode_code, 3'd2);
        tmr_irq = 4'b1010; tick(); tmr_irq = '0;
        chk("R6 unkept timers ignored", mode_code, 3'd2);
        sci_irq = 1; tick(); sci_irq = 0;
        chk("R6 unkept sci ignored", mode_code, 3'd2);
        wait_strobe = 1; tick(); wait_strobe = 0;
        chk("R12 wait strobe in stop", mode_code, 3'd2);
        tmr_irq = 4'b0100; tick(); tmr_irq = '0;
        chk("R6 kept timer wakes", mode_code, 3'd0);
        enter_stop();
        lvi_irq = 1; tick(); lvi_irq = 0;
        chk("R6 low voltage wakes", mode_code, 3'd0);
        sci_stop_keep = 1; enter_stop();
        sci_irq = 1; tick(); sci_irq = 0;
        chk("R6 kept sci wakes", mode_code, 3'd0);
        enter_stop();
        dbg_req = 1; tick(); dbg_req = 0;
        chk("R6 debug wakes stop", mode_code, 3'd0);
        tmr_stop_keep = '0; sci_stop_keep = 0;
    endtask

    task automatic t_standby();
        cfg_relax_sel = 1; cfg_pll_off = 1; cfg_osc_stby = 1;
        tick();
        chk("R7 three bits stay run", mode_code, 3'd0);
        cfg_reg_stby = 1; pll_locked = 0; tick();
        chk_out("R7 standby", 7'b1111011, 4'b1111, 3'd3);
        stop_strobe = 1; tick(); stop_strobe = 0;
        chk("R12 stop strobe in standby", mode_code, 3'd3);
        cfg_relax_sel = 0; cfg_pll_off = 0; cfg_osc_stby = 0; cfg_reg_stby = 0;
        tick();
        chk("R8 waits for lock", mode_code, 3'd3);
        pll_locked = 1; cfg_reg_stby = 1; tick();
        chk("R8 partial config stays", mode_code, 3'd3);
        cfg_reg_stby = 0; tick();
        chk_out("R8 back to run", 7'b1111110, 4'b1111, 3'd0);
    endtask

    task automatic t_pdn();
        cfg_relax_sel = 1; cfg_pll_off = 1; cfg_osc_stby = 1; cfg_reg_stby = 1;
        tick();
        cfg_osc_off = 1; tick();
        chk_out("R9 power-down", 7'b0000001, 4'b0000, 3'd4);
        cfg_relax_sel = 0; cfg_pll_off = 0; cfg_osc_stby = 0; cfg_reg_stby = 0; cfg_osc_off = 0;
        sw_rst = 1; tick(); sw_rst = 0;
        chk("R10 sw reset ignored", mode_code, 3'd4);
        wdog_rst = 1; irq_req = 8'h01; lvi_irq = 1; dbg_req = 1; tick();
        wdog_rst = 0; irq_req = '0; lvi_irq = 0; dbg_req = 0;
        chk("R10 events ignored", mode_code, 3'd4);
        ext_rst = 1; tick(); ext_rst = 0;
        chk("R10 ext reset leaves", mode_code, 3'd0);
        cfg_relax_sel = 1; cfg_pll_off = 1; cfg_osc_stby = 1; cfg_reg_stby = 1;
        tick(); cfg_osc_off = 1; tick();
        cfg_relax_sel = 0; cfg_pll_off = 0; cfg_osc_stby = 0; cfg_reg_stby = 0; cfg_osc_off = 0;
        rst_n = 0; tick(); rst_n = 1;
        chk("R10 power-on reset leaves", mode_code, 3'd0);
    endtask

    task automatic t_resets();
        wait_strobe = 1; tick(); wait_strobe = 0;
        sw_rst = 1; tick(); sw_rst = 0;
        chk("R11 sw reset from wait", mode_code, 3'd0);
        enter_stop();
        wdog_rst = 1; tick(); wdog_rst = 0;
        chk("R11 watchdog from stop", mode_code, 3'd0);
        cfg_relax_sel = 1; cfg_pll_off = 1; cfg_osc_stby = 1; cfg_reg_stby = 1; pll_locked = 0;
        tick();
        chk("R11 standby reached", mode_code, 3'd3);
        cfg_relax_sel = 0; cfg_pll_off = 0; cfg_osc_stby = 0; cfg_reg_stby = 0;
        ext_rst = 1; tick(); ext_rst = 0;
        chk("R11 ext reset from standby", mode_code, 3'd0);
        pll_locked = 1;
        stop_strobe = 1; ext_rst = 1; tick(); stop_strobe = 0; ext_rst = 0;
        chk("R11 reset beats strobe", mode_code, 3'd0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        t_reset();
        t_wait();
        t_stop();
        t_standby();
        t_pdn();
        t_resets();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule